// File: doc/BRIEF.md
# First-Fire Class Decoder for a Single-Spike Output Layer

This block sits behind a layer of spiking output neurons in which each neuron fires at most once per frame. In inference mode it performs a temporal winner-take-all: the lowest-index neuron among those that fire in the earliest spiking cycle decides the class. It then raises a cut vector that shuts down every neuron for the rest of the frame. The class number equals the index of the winning neuron. The extra class N means that no neuron fired before the frame ended. Read as a code, class c is c "silent" marks followed by one "fired" mark, so it is a prefix code scanned from neuron 0 upward.

In training mode the same code is run in reverse from a target class. Neurons below the target must stay silent. The target neuron must fire. Neurons above the target take no part and are never flagged. When the target is N or more, all neurons must stay silent. At frame end the block compares the spikes it saw against this pattern and presents one error vector for the weight-update logic. Each flagged bit carries a type: a spike that should not have happened, or a spike that was missing.

Top module: `first_fire_decoder`

## Requirements
- R1: After reset, `cut_out`, `class_valid`, `err_valid`, `err_vec`, `err_type` and `class_out` are all zero.
- R2: In inference mode, if spikes appear in a cycle of an open frame, `class_valid` pulses for one cycle on the next cycle, and `class_out` equals the index of the neuron that fired.
- R3: If several neurons fire in the same cycle, the lowest index wins.
- R4: From the cycle that reports a class, `cut_out` is all ones and stays so until the next `frame_start`. Later spikes in that frame produce no further `class_valid`.
- R5: If no neuron fires in an inference frame, `frame_end` produces `class_valid` on the next cycle with `class_out` = N (all neurons silent).
- R6: Spikes and `frame_end` outside an open frame, and spikes in the `frame_start` cycle, have no effect on any output.
- R7: In training mode, for target c < N, neurons 0..c-1 must not fire, neuron c must fire, and neurons above c are independent. A target of N or more requires all neurons to stay silent.
- R8: A neuron that must not fire but did fire during the training frame is flagged in `err_vec` with `err_type` bit = 1 (false fire).
- R9: A neuron that must fire but did not fire is flagged in `err_vec` with `err_type` bit = 0 (false miss).
- R10: Independent neurons are never flagged, whatever their spikes.
- R11: A training frame reports one cycle after `frame_end` with a single-cycle `err_valid`, and `err_vec` is zero whenever `err_valid` is low. Spikes seen in the `frame_end` cycle count. Training mode never pulses `class_valid` and keeps `cut_out` low until frame end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Opens a frame; mode and target are sampled here |
| frame_end | input | 1 | Frame window has expired |
| learn_mode | input | 1 | 1 = training frame, 0 = inference frame |
| target_class | input | CLS_W | Class to train toward |
| spike_in | input | N_NEURONS | One spike bit per output neuron |
| cut_out | output | N_NEURONS | Shut-down request to each neuron |
| class_out | output | CLS_W | Decoded class, held until the next decision |
| class_valid | output | 1 | One-cycle strobe for `class_out` |
| err_vec | output | N_NEURONS | Neurons flagged for weight update |
| err_type | output | N_NEURONS | 1 = false fire, 0 = false miss, per flagged neuron |
| err_valid | output | 1 | One-cycle strobe for the error vector |

## Verification
The assertions assume that `frame_start` is a single-cycle pulse that is never driven together with `frame_end`. They also assume that `target_class` is stable only at the `frame_start` cycle, which is why the checker keeps its own copy of the target. The bench drives every control and spike bit on the falling edge and always raises `frame_start` and `frame_end` in separate cycles. It also changes `target_class` after frames open, which shows that only the sampled value matters.

// File: rtl/ffd_pkg.sv
// Shared types for the first-fire decoder.
// Assumes nothing beyond the IEEE 1800-2017 enum rules.
package ffd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // no frame open
        ST_INFER = 2'd1,   // inference frame, waiting for a first spike
        ST_TRAIN = 2'd2    // training frame, collecting spikes until frame end
    } ffd_state_e;
endpackage

// File: rtl/ffd_first_fire.sv
// Priority pick of the lowest-index active spike.
// Assumes CLS_W can hold N_NEURONS; purely combinational.
module ffd_first_fire #(
    parameter int N_NEURONS = 4,
    parameter int CLS_W     = $clog2(N_NEURONS + 1)
) (
    input  logic [N_NEURONS-1:0] live,
    output logic                 any_hit,
    output logic [CLS_W-1:0]     win_idx
);
    // Scan from the top so the lowest index is written last and wins.
    always_comb begin
        win_idx = '0;
        for (int k = N_NEURONS - 1; k >= 0; k--) begin
            if (live[k]) win_idx = CLS_W'(k);
        end
    end

    // Any spike at all in this cycle.
    assign any_hit = |live;
endmodule

// File: rtl/ffd_target_map.sv
// Reverse of the prefix code: turns a target class into the desired firing
// pattern. Neurons below the target must be silent, the target must fire,
// and the rest are independent. Assumes the target is held by the caller.
module ffd_target_map #(
    parameter int N_NEURONS = 4,
    parameter int CLS_W     = $clog2(N_NEURONS + 1)
) (
    input  logic [CLS_W-1:0]     target,
    output logic [N_NEURONS-1:0] must_fire,
    output logic [N_NEURONS-1:0] must_quiet
);
    // One comparison pair per neuron position.
    for (genvar j = 0; j < N_NEURONS; j++) begin : g_map
        assign must_fire[j]  = (target == CLS_W'(j));
        assign must_quiet[j] = (target >  CLS_W'(j));
    end
endmodule

// File: rtl/ffd_error_check.sv
// Compares observed spikes against the desired pattern. Independent neurons
// (neither must_fire nor must_quiet) can never be flagged.
// Assumes must_fire and must_quiet never overlap.
module ffd_error_check #(
    parameter int N_NEURONS = 4
) (
    input  logic [N_NEURONS-1:0] must_fire,
    input  logic [N_NEURONS-1:0] must_quiet,
    input  logic [N_NEURONS-1:0] fired,
    output logic [N_NEURONS-1:0] flag,
    output logic [N_NEURONS-1:0] is_false_fire
);
    logic [N_NEURONS-1:0] miss_bits;
    logic [N_NEURONS-1:0] fire_bits;

    // Split the two error kinds, then merge them into a flag plus a type.
    always_comb begin
        miss_bits     = must_fire  & ~fired;
        fire_bits     = must_quiet &  fired;
        flag          = miss_bits | fire_bits;
        is_false_fire = fire_bits;
    end
endmodule

// File: rtl/first_fire_decoder.sv
// Top level: frame control, first-fire class decode with cut-off in
// inference mode, and frame-end error reporting in training mode.
// Assumes frame_start is a one-cycle pulse that is not coincident with
// frame_end; spikes in the frame_start cycle are not counted.
module first_fire_decoder #(
    parameter int N_NEURONS = 4,
    parameter int CLS_W     = $clog2(N_NEURONS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_start,
    input  logic                 frame_end,
    input  logic                 learn_mode,
    input  logic [CLS_W-1:0]     target_class,
    input  logic [N_NEURONS-1:0] spike_in,
    output logic [N_NEURONS-1:0] cut_out,
    output logic [CLS_W-1:0]     class_out,
    output logic                 class_valid,
    output logic [N_NEURONS-1:0] err_vec,
    output logic [N_NEURONS-1:0] err_type,
    output logic                 err_valid
);
    import ffd_pkg::*;

    localparam logic [CLS_W-1:0] SILENT_CLASS = CLS_W'(N_NEURONS);

    ffd_state_e            state_q;
    logic [CLS_W-1:0]      tgt_q;
    logic [N_NEURONS-1:0]  fired_q;
    logic [N_NEURONS-1:0]  cut_q;
    logic [CLS_W-1:0]      class_q;
    logic                  class_vld_q;
    logic [N_NEURONS-1:0]  err_vec_q;
    logic [N_NEURONS-1:0]  err_type_q;
    logic                  err_vld_q;

    logic [N_NEURONS-1:0]  live;
    logic [N_NEURONS-1:0]  fired_all;
    logic                  any_hit;
    logic [CLS_W-1:0]      win_idx;
    logic [N_NEURONS-1:0]  must_fire;
    logic [N_NEURONS-1:0]  must_quiet;
    logic [N_NEURONS-1:0]  flag;
    logic [N_NEURONS-1:0]  ff_kind;

    // Spikes from neurons that are not cut, and the running training record.
    always_comb begin
        live      = spike_in & ~cut_q;
        fired_all = fired_q | spike_in;
    end

    ffd_first_fire #(.N_NEURONS(N_NEURONS), .CLS_W(CLS_W)) i_first (
        .live    (live),
        .any_hit (any_hit),
        .win_idx (win_idx)
    );

    ffd_target_map #(.N_NEURONS(N_NEURONS), .CLS_W(CLS_W)) i_map (
        .target     (tgt_q),
        .must_fire  (must_fire),
        .must_quiet (must_quiet)
    );

    ffd_error_check #(.N_NEURONS(N_NEURONS)) i_chk (
        .must_fire     (must_fire),
        .must_quiet    (must_quiet),
        .fired         (fired_all),
        .flag          (flag),
        .is_false_fire (ff_kind)
    );

    // Frame sequencing, class decision and error capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            tgt_q       <= '0;
            fired_q     <= '0;
            cut_q       <= '0;
            class_q     <= '0;
            class_vld_q <= 1'b0;
            err_vec_q   <= '0;
            err_type_q  <= '0;
            err_vld_q   <= 1'b0;
        end else begin
            class_vld_q <= 1'b0;
            err_vld_q   <= 1'b0;
            err_vec_q   <= '0;
            err_type_q  <= '0;
            if (frame_start) begin
                state_q <= learn_mode ? ST_TRAIN : ST_INFER;
                tgt_q   <= target_class;
                fired_q <= '0;
                cut_q   <= '0;
            end else begin
                case (state_q)
                    ST_INFER: begin
                        if (any_hit) begin
                            class_q     <= win_idx;
                            class_vld_q <= 1'b1;
                            cut_q       <= '1;
                            state_q     <= ST_IDLE;
                        end else if (frame_end) begin
                            class_q     <= SILENT_CLASS;
                            class_vld_q <= 1'b1;
                            cut_q       <= '1;
                            state_q     <= ST_IDLE;
                        end
                    end
                    ST_TRAIN: begin
                        fired_q <= fired_all;
                        if (frame_end) begin
                            err_vec_q  <= flag;
                            err_type_q <= ff_kind;
                            err_vld_q  <= 1'b1;
                            cut_q      <= '1;
                            state_q    <= ST_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign cut_out     = cut_q;
    assign class_out   = class_q;
    assign class_valid = class_vld_q;
    assign err_vec     = err_vec_q;
    assign err_type    = err_type_q;
    assign err_valid   = err_vld_q;
endmodule

// File: rtl/first_fire_decoder_sva.sv
// Checker for first_fire_decoder, attached by bind. It keeps its own copy
// of the target sampled at frame_start to know which neurons take part.
module first_fire_decoder_sva #(
    parameter int N_NEURONS = 4,
    parameter int CLS_W     = $clog2(N_NEURONS + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 frame_start,
    input logic                 learn_mode,
    input logic [CLS_W-1:0]     target_class,
    input logic [N_NEURONS-1:0] cut_out,
    input logic [CLS_W-1:0]     class_out,
    input logic                 class_valid,
    input logic [N_NEURONS-1:0] err_vec,
    input logic                 err_valid
);
    logic [CLS_W-1:0]     seen_tgt;
    logic                 seen_learn;
    logic [N_NEURONS-1:0] takes_part;

    // Record the target and mode of the most recent frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_tgt   <= '0;
            seen_learn <= 1'b0;
        end else if (frame_start) begin
            seen_tgt   <= target_class;
            seen_learn <= learn_mode;
        end
    end

    // Participating neurons are those at or below the target index.
    always_comb begin
        for (int j = 0; j < N_NEURONS; j++) begin
            takes_part[j] = (j <= int'(seen_tgt));
        end
    end

    p_class_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        class_valid |-> (int'(class_out) <= N_NEURONS));

    p_class_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        class_valid |=> !class_valid);

    p_cut_on_class_r4: assert property (@(posedge clk) disable iff (!rst_n)
        class_valid |-> (cut_out == '1));

    p_cut_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((cut_out == '1) && !frame_start) |=> (cut_out == '1));

    p_indep_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> ((err_vec & ~takes_part) == '0));

    p_err_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !err_valid |-> (err_vec == '0));

    p_no_class_in_train_r11: assert property (@(posedge clk) disable iff (!rst_n)
        seen_learn |-> !class_valid);

    p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({class_valid, err_valid}));
endmodule

bind first_fire_decoder first_fire_decoder_sva #(
    .N_NEURONS(N_NEURONS), .CLS_W(CLS_W)
) i_first_fire_decoder_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start  (frame_start),
    .learn_mode   (learn_mode),
    .target_class (target_class),
    .cut_out      (cut_out),
    .class_out    (class_out),
    .class_valid  (class_valid),
    .err_vec      (err_vec),
    .err_valid    (err_valid)
);

// File: tb/test_first_fire_decoder.sv
// Directed bench: one task per scenario, each checking its own results.
module test_first_fire_decoder;
    localparam int N     = 4;
    localparam int CW    = $clog2(N + 1);
    localparam int HALFP = 2;   // 4 ns period

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic          frame_end = 1'b0;
    logic          learn_mode = 1'b0;
    logic [CW-1:0] target_class = '0;
    logic [N-1:0]  spike_in = '0;
    logic [N-1:0]  cut_out;
    logic [CW-1:0] class_out;
    logic          class_valid;
    logic [N-1:0]  err_vec;
    logic [N-1:0]  err_type;
    logic          err_valid;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #HALFP clk = ~clk;

    first_fire_decoder #(.N_NEURONS(N)) i_first_fire_decoder (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .frame_end(frame_end), .learn_mode(learn_mode),
        .target_class(target_class), .spike_in(spike_in),
        .cut_out(cut_out), .class_out(class_out), .class_valid(class_valid),
        .err_vec(err_vec), .err_type(err_type), .err_valid(err_valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reference: lowest set bit index, or N when empty.
    function automatic int ref_class(input logic [N-1:0] m);
        for (int k = 0; k < N; k++) if (m[k]) return k;
        return N;
    endfunction

    // Reference error vector and type from target and fired set.
    function automatic logic [2*N-1:0] ref_err(input int tgt, input logic [N-1:0] f);
        logic [N-1:0] e = '0;
        logic [N-1:0] t = '0;
        for (int j = 0; j < N; j++) begin
            if (j < tgt && f[j]) begin e[j] = 1'b1; t[j] = 1'b1; end
            if (j == tgt && !f[j]) e[j] = 1'b1;
        end
        return {t, e};
    endfunction

    task automatic open_frame(input logic lm, input int tgt);
        @(negedge clk);
        frame_start  = 1'b1;
        learn_mode   = lm;
        target_class = CW'(tgt);
        spike_in     = 4'b1111;   // spikes in the start cycle must not count (R6)
        @(negedge clk);
        frame_start  = 1'b0;
        spike_in     = '0;
        target_class = CW'(N - 1 - tgt);   // only the sampled target matters
    endtask

    task automatic t_reset();
        chk("R1 cut", 32'(cut_out), 0);
        chk("R1 class_valid", 32'(class_valid), 0);
        chk("R1 err_valid", 32'(err_valid), 0);
        chk("R1 err_vec", 32'(err_vec), 0);
        chk("R1 class_out", 32'(class_out), 0);
    endtask

    task automatic t_infer(input logic [N-1:0] m, input string req);
        open_frame(1'b0, 0);
        @(negedge clk);   // idle cycle, no spikes
        chk({req, " no early strobe"}, 32'(class_valid), 0);
        spike_in = m;
        @(negedge clk);
        spike_in = '0;
        chk({req, " valid"}, 32'(class_valid), 1);
        chk({req, " class"}, 32'(class_out), 32'(ref_class(m)));
        chk("R4 cut on decision", 32'(cut_out), 32'(4'b1111));
        // Later spikes in the same frame: no second decision
        spike_in = 4'b0001;
        @(negedge clk);
        spike_in = '0;
        chk("R4 no second strobe", 32'(class_valid), 0);
        chk("R4 cut held", 32'(cut_out), 32'(4'b1111));
        chk("R4 class held", 32'(class_out), 32'(ref_class(m)));
    endtask

    task automatic t_silent();
        open_frame(1'b0, 0);
        chk("R6 start-cycle spikes ignored", 32'(class_valid), 0);
        repeat (3) @(negedge clk);
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
        chk("R5 valid", 32'(class_valid), 1);
        chk("R5 class N", 32'(class_out), 32'(N));
    endtask

    task automatic t_outside();
        // Frame closed: spikes and frame_end have no effect
        spike_in  = 4'b0100;
        frame_end = 1'b1;
        @(negedge clk);
        spike_in  = '0;
        frame_end = 1'b0;
        @(negedge clk);
        chk("R6 no class", 32'(class_valid), 0);
        chk("R6 no err", 32'(err_valid), 0);
        chk("R6 class unchanged", 32'(class_out), 32'(N));
    endtask

    task automatic t_train(input int tgt, input logic [N-1:0] early,
                           input logic [N-1:0] last, input string req);
        logic [2*N-1:0] exp;
        open_frame(1'b1, tgt);
        chk("R11 no cut in training", 32'(cut_out), 0);
        spike_in = early;
        @(negedge clk);
        spike_in = '0;
        chk("R11 no class in training", 32'(class_valid), 0);
        chk("R11 cut low mid-frame", 32'(cut_out), 0);
        chk("R11 no early err", 32'(err_valid), 0);
        @(negedge clk);
        frame_end = 1'b1;
        spike_in  = last;
        @(negedge clk);
        frame_end = 1'b0;
        spike_in  = '0;
        exp = ref_err(tgt, early | last);
        chk({req, " err_valid"}, 32'(err_valid), 1);
        chk({req, " err_vec"}, 32'(err_vec), 32'(exp[N-1:0]));
        chk({req, " err_type"}, 32'(err_type & err_vec), 32'(exp[2*N-1:N]));
        @(negedge clk);
        chk("R11 err pulse ends", 32'(err_valid), 0);
        chk("R11 err_vec cleared", 32'(err_vec), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_infer(4'b0100, "R2 single fire");
        t_infer(4'b0001, "R2 neuron zero");
        t_infer(4'b0110, "R3 tie");
        t_infer(4'b1010, "R3 tie upper");
        t_silent();
        t_outside();
        // R8: target 2, neuron 0 fires early -> false fire; R9: neuron 2 silent
        // -> false miss; R10: neuron 3 is independent and not flagged
        t_train(2, 4'b1001, 4'b0000, "R8 R9 R10 faults");
        // R7: target 1, neuron 1 fires in the end cycle, neuron 3 independent
        t_train(1, 4'b1000, 4'b0010, "R7 clean");
        // R7: target N, every neuron must stay silent; neuron 3 fires
        t_train(N, 4'b0000, 4'b1000, "R7 all silent");
        // R9: target 3, nothing fires -> miss on neuron 3 only
        t_train(3, 4'b0000, 4'b0000, "R9 miss");
        // R8: target 0 means no must-quiet neuron; higher spikes are independent
        t_train(0, 4'b1110, 4'b0001, "R10 upper independent");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(HALFP * 2 * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule